// File: doc/BRIEF.md
# Raster Beam Position Counter with Refresh-Slot Strobes

This block keeps track of where the video beam is on a raster display. A horizontal counter advances by one on every colour-clock enable pulse. Lines alternate between a short length of 227 colour clocks and a long length of 228. A vertical counter advances at the end of each line. A frame holds 262 lines, or 263 when the long-frame flag is set. With interlace enabled, that flag flips at every frame boundary.

Each line has four refresh slots, at horizontal counts 1, 3, 5 and 7. In these slots the block drives an 8-bit strobe code onto a destination address bus, which tells downstream chips about sync, blanking and line length. The first slot always carries one of three sync codes, chosen by the current line: equalisation, vertical blank or plain sync. The second slot marks long lines. Any slot or cycle with nothing to say carries the null code 0xFF.

The processor reads the beam position through two packed words and can write either word to reposition the beam.

Top module: `beam_counter`

## Requirements
- R1: Reset clears the horizontal count, the vertical count, the long-line flag and the long-frame flag to 0. While `cck_en` is low and no write occurs, both counts hold their values.
- R2: The first line after reset is short. A short line ends after horizontal count 226 and a long line ends after count 228 minus one (227). The horizontal count then returns to 0, and `long_line` inverts at every line end.
- R3: The vertical count increments at each line end. When `lof` is 0 it returns to 0 after line 261; when `lof` is 1 it returns to 0 after line 262.
- R4: At horizontal count 1, `dest_addr` depends on the vertical count. It is 0x38 on lines 0 to 8, 0x3A on lines 9 to 20, and 0x3C on all other lines.
- R5: At horizontal count 3, `dest_addr` is 0x3E when `long_line` is 1.
- R6: At every other horizontal count, `dest_addr` is 0xFF. This includes counts 5 and 7, and count 3 on a short line.
- R7: `pos_word` holds vertical bits 7:0 in bits 15:8 and the horizontal count in bits 7:0.
- R8: `vert_word` holds `lof` in bit 15 and vertical bit 8 in bit 0. Bits 14:1 are always zero.
- R9: When `lace_en` is 1 at a frame end, `lof` inverts. When `lace_en` is 0, `lof` changes only through a write.
- R10: A write with `wr_sel`=0 loads vertical bits 7:0 from `wr_data[15:8]` and the horizontal count from `wr_data[7:0]`. A write with `wr_sel`=1 loads `lof` from bit 15 and vertical bit 8 from bit 0. A write takes priority over counting in the same cycle. A horizontal count loaded at or beyond the line end returns to 0 on the next advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cck_en | input | 1 | Colour-clock enable; counters advance when high |
| lace_en | input | 1 | Interlace enable; lets the long-frame flag toggle per frame |
| wr_en | input | 1 | Processor write strobe |
| wr_sel | input | 1 | 0 = position word, 1 = vertical word |
| wr_data | input | 16 | Write data |
| hcount | output | 8 | Horizontal count in colour clocks |
| vcount | output | 9 | Vertical line count |
| long_line | output | 1 | Current line is long |
| lof | output | 1 | Long-frame flag |
| dest_addr | output | 8 | Refresh-slot strobe code or 0xFF |
| pos_word | output | 16 | Packed low vertical and horizontal position |
| vert_word | output | 16 | Long-frame flag and vertical MSB |

## Verification
The bench places the beam near the frame end with both flag values. A design that ignored `lof` when choosing the frame length would wrap one line early or late, and one that ignored `lace_en` would leave the flag unchanged. It loads lines 8, 9, 20 and 21 to land on the edges of the sync-code ranges, where an off-by-one comparison would put out the wrong code in slot 1. It runs whole short and long lines, where a wrong line length would shift every later slot or mark the wrong lines as long. It also loads a horizontal count past the line end, which a design using an equality test would carry on counting past instead of wrapping.

// File: rtl/beam_counter.sv
module beam_counter #(
  parameter int HW        = 8,
  parameter int VW        = 9,
  parameter int H_SHORT   = 227,
  parameter int V_LINES   = 262,
  parameter int EQU_LAST  = 8,
  parameter int VBL_LAST  = 20,
  parameter int SLOT_BASE = 1,
  parameter int SLOTS     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cck_en,
  input  logic          lace_en,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [15:0]   wr_data,
  output logic [HW-1:0] hcount,
  output logic [VW-1:0] vcount,
  output logic          long_line,
  output logic          lof,
  output logic [7:0]    dest_addr,
  output logic [15:0]   pos_word,
  output logic [15:0]   vert_word
);
  localparam logic [HW-1:0] H_LAST_S = HW'(H_SHORT - 1);
  localparam logic [HW-1:0] H_LAST_L = HW'(H_SHORT);
  localparam logic [VW-1:0] V_LAST_S = VW'(V_LINES - 1);
  localparam logic [VW-1:0] V_LAST_L = VW'(V_LINES);
  localparam logic [7:0] C_EQU  = 8'h38;
  localparam logic [7:0] C_VBL  = 8'h3A;
  localparam logic [7:0] C_HS   = 8'h3C;
  localparam logic [7:0] C_LONG = 8'h3E;
  localparam logic [7:0] C_NULL = 8'hFF;

  logic h_end, v_end;
  logic [SLOTS-1:0] slot_hit;
  logic [7:0] sync_code;

  assign h_end = hcount >= (long_line ? H_LAST_L : H_LAST_S);
  assign v_end = vcount >= (lof ? V_LAST_L : V_LAST_S);

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign slot_hit[k] = (hcount == HW'(SLOT_BASE + 2 * k));
  end

  assign sync_code = (vcount <= VW'(EQU_LAST)) ? C_EQU :
                     (vcount <= VW'(VBL_LAST)) ? C_VBL : C_HS;

  always_comb begin
    dest_addr = C_NULL;
    if (slot_hit[0])
      dest_addr = sync_code;
    else if (slot_hit[1] && long_line)
      dest_addr = C_LONG;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcount    <= '0;
      vcount    <= '0;
      long_line <= 1'b0;
      lof       <= 1'b0;
    end else if (wr_en) begin
      if (!wr_sel) begin
        vcount[7:0] <= wr_data[15:8];
        hcount      <= wr_data[HW-1:0];
      end else begin
        lof       <= wr_data[15];
        vcount[8] <= wr_data[0];
      end
    end else if (cck_en) begin
      if (h_end) begin
        hcount    <= '0;
        long_line <= ~long_line;
        if (v_end) begin
          vcount <= '0;
          if (lace_en) lof <= ~lof;
        end else begin
          vcount <= vcount + 1'b1;
        end
      end else begin
        hcount <= hcount + 1'b1;
      end
    end
  end

  assign pos_word  = {vcount[7:0], hcount[7:0]};
  assign vert_word = {lof, 14'd0, vcount[8]};
endmodule

// File: rtl/beam_counter_chk.sv
module beam_counter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cck_en,
  input logic        lace_en,
  input logic        wr_en,
  input logic [7:0]  hcount,
  input logic [8:0]  vcount,
  input logic        long_line,
  input logic        lof,
  input logic [7:0]  dest_addr,
  input logic [15:0] vert_word
);
  logic [7:0] h_last;
  logic [8:0] v_last;
  logic       advance;
  assign h_last  = long_line ? 8'd227 : 8'd226;
  assign v_last  = lof ? 9'd262 : 9'd261;
  assign advance = cck_en && !wr_en;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cck_en && !wr_en) |=> ($stable(hcount) && $stable(vcount))); // R1
  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && hcount == h_last) |=> (hcount == 8'd0 && long_line != $past(long_line))); // R2
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && hcount == h_last && vcount == v_last) |=> (vcount == 9'd0)); // R3
  AST_SYNC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount == 8'd1) |-> (dest_addr == 8'h38 || dest_addr == 8'h3A || dest_addr == 8'h3C)); // R4
  AST_LONG_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_addr == 8'h3E) |-> long_line); // R5
  AST_NULL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount != 8'd1 && hcount != 8'd3) |-> (dest_addr == 8'hFF)); // R6
  AST_VERT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    vert_word[14:1] == 14'd0); // R8
  AST_LOF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!lace_en && !wr_en) |=> $stable(lof)); // R9
  AST_LOF_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (lace_en && advance && hcount == h_last && vcount == v_last) |=> (lof != $past(lof))); // R9
endmodule

bind beam_counter beam_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cck_en(cck_en), .lace_en(lace_en), .wr_en(wr_en),
  .hcount(hcount), .vcount(vcount), .long_line(long_line), .lof(lof),
  .dest_addr(dest_addr), .vert_word(vert_word)
);

// File: tb/tb_beam_counter.sv
module tb_beam_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cck_en = 1'b0, lace_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  hcount;
  logic [8:0]  vcount;
  logic        long_line, lof;
  logic [7:0]  dest_addr;
  logic [15:0] pos_word, vert_word;

  always #2 clk = ~clk;

  beam_counter dut (
    .clk(clk), .rst_n(rst_n), .cck_en(cck_en), .lace_en(lace_en),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hcount(hcount), .vcount(vcount), .long_line(long_line), .lof(lof),
    .dest_addr(dest_addr), .pos_word(pos_word), .vert_word(vert_word)
  );

  typedef struct packed {
    logic [7:0] h; logic [8:0] v; logic ll; logic lf;
    logic [7:0] d; logic [15:0] pw; logic [15:0] vw;
  } obs_t;

  obs_t  expq[$];
  string tagq[$];
  int checks = 0, fails = 0;
  logic [7:0] mh = '0;
  logic [8:0] mv = '0;
  logic mll = 1'b0, mlf = 1'b0;

  function automatic obs_t model_obs();
    obs_t o;
    o.h = mh; o.v = mv; o.ll = mll; o.lf = mlf;
    if (mh == 8'd1)
      o.d = (mv <= 9'd8) ? 8'h38 : (mv <= 9'd20) ? 8'h3A : 8'h3C;
    else if (mh == 8'd3 && mll)
      o.d = 8'h3E;
    else
      o.d = 8'hFF;
    o.pw = {mv[7:0], mh};
    o.vw = {mlf, 14'd0, mv[8]};
    return o;
  endfunction

  function automatic obs_t dut_obs();
    obs_t o;
    o.h = hcount; o.v = vcount; o.ll = long_line; o.lf = lof;
    o.d = dest_addr; o.pw = pos_word; o.vw = vert_word;
    return o;
  endfunction

  task automatic step(input bit ce, input bit la, input bit we, input bit ws,
                      input logic [15:0] wd, input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cck_en = ce; lace_en = la; wr_en = we; wr_sel = ws; wr_data = wd;
      if (we) begin
        if (!ws) begin mv[7:0] = wd[15:8]; mh = wd[7:0]; end
        else begin mlf = wd[15]; mv[8] = wd[0]; end
      end else if (ce) begin
        if (mh >= (mll ? 8'd227 : 8'd226)) begin
          mh = '0; mll = ~mll;
          if (mv >= (mlf ? 9'd262 : 9'd261)) begin
            mv = '0;
            if (la) mlf = ~mlf;
          end else mv = mv + 1'b1;
        end else mh = mh + 1'b1;
      end
      expq.push_back(model_obs());
      tagq.push_back(tag);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (expq.size() > 0) begin
      obs_t e, a;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      a = dut_obs();
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: got h=%0d v=%0d ll=%b lof=%b d=%h pw=%h vw=%h exp h=%0d v=%0d ll=%b lof=%b d=%h pw=%h vw=%h",
                 t, a.h, a.v, a.ll, a.lf, a.d, a.pw, a.vw, e.h, e.v, e.ll, e.lf, e.d, e.pw, e.vw);
      end
    end
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (dut_obs() !== model_obs()) begin
      fails++;
      $display("FAIL R1 reset: got h=%0d v=%0d ll=%b lof=%b exp zeros",
               hcount, vcount, long_line, lof);
    end
    rst_n = 1'b1;
    step(1, 0, 0, 0, 16'h0, "R2 R5 R6 R7 run", 690);
    for (int i = 0; i < 20; i++) step(i % 2, 0, 0, 0, 16'h0, "R1 hold", 1);
    step(1, 0, 1, 0, 16'h0800, "R10 load", 1);
    step(1, 0, 0, 0, 16'h0, "R4 line8", 8);
    step(1, 0, 1, 0, 16'h0900, "R10 load", 1);
    step(1, 0, 0, 0, 16'h0, "R4 line9", 8);
    step(1, 0, 1, 0, 16'h1400, "R10 load", 1);
    step(1, 0, 0, 0, 16'h0, "R4 line20", 8);
    step(1, 0, 1, 0, 16'h1500, "R10 load", 1);
    step(1, 0, 0, 0, 16'h0, "R4 line21", 8);
    step(1, 0, 1, 1, 16'hFFFF, "R8 vert pad", 1);
    step(0, 0, 0, 0, 16'h0, "R8 vert pad", 2);
    step(1, 0, 1, 1, 16'h8001, "R10 vert load", 1);
    step(1, 0, 1, 0, 16'h05DC, "R10 pos load", 1);
    step(1, 0, 0, 0, 16'h0, "R3 long frame", 300);
    step(1, 1, 1, 1, 16'h8001, "R10 vert load", 1);
    step(1, 1, 1, 0, 16'h06DC, "R10 pos load", 1);
    step(1, 1, 0, 0, 16'h0, "R9 lace flip", 20);
    step(1, 1, 1, 1, 16'h0001, "R10 vert load", 1);
    step(1, 1, 1, 0, 16'h05DC, "R10 pos load", 1);
    step(1, 1, 0, 0, 16'h0, "R9 lace flip", 20);
    step(1, 0, 1, 0, 16'h30F0, "R10 beyond end", 1);
    step(1, 0, 0, 0, 16'h0, "R10 wrap", 3);
    step(1, 0, 0, 0, 16'h0, "R7 R6 run", 240);
    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule